// File: doc/BRIEF.md
# DES / Triple-DES Block Chaining Engine

This block encrypts or decrypts one 64-bit block at a time with the Data Encryption Standard, either with a single 64-bit key or as a three-key encrypt-decrypt-encrypt cascade. It supports electronic codebook (ECB) and cipher block chaining (CBC) operation. A single iterative core performs one Feistel round per clock and is reused for all three key passes. Subkeys come from rotating shift registers rather than from a stored table.

A block enters on a valid/ready input made of two 32-bit words. The result leaves on a valid/ready output. Key words and the mode pins are plain control inputs. The mode pins are sampled when a block is accepted. Each key must stay stable from the accepting edge until the key pass that uses it has started. In CBC operation the block keeps the chaining value in an internal register and updates it in hardware. That register is visible on `iv_out`, so software can save it and later reload it with `iv_load` to continue the stream.

Back-pressure rules:
- `in_ready` is high only while the engine is empty.
- A result stays on the output, unchanged, until `out_ready` is seen high with `out_valid`.
- A new block can be accepted only on a later cycle.

Top module: `tdes_chain_engine`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `iv_out` is all zeros.
- R2: In single-key ECB encrypt mode the output is the DES encryption of the input under `key1`. `din_hi` and `dout_hi` carry bits 1 to 32 of the standard block, with bit 1 the MSB, and `din_lo`/`dout_lo` carry bits 33 to 64. Example: key 133457799BBCDFF1 encrypts 0123456789ABCDEF to 85E813540F0AB405.
- R3: In single-key decrypt mode (`cfg_encrypt`=0) the output is the DES decryption under `key1`, so decrypting an encrypted block returns the original block. This holds in both single- and triple-key modes.
- R4: With `cfg_triple`=1 and `cfg_encrypt`=1 the passes are: encrypt with `key1`, then decrypt with `key2`, then encrypt with `key3`.
- R5: With `cfg_triple`=1 and `cfg_encrypt`=0 the passes are: decrypt with `key3`, then encrypt with `key2`, then decrypt with `key1`.
- R6: CBC encrypt (`cfg_chain`=1, `cfg_encrypt`=1) enciphers the input XORed with the chaining value. The ciphertext then becomes the new chaining value.
- R7: CBC decrypt (`cfg_chain`=1, `cfg_encrypt`=0) XORs the chaining value into the deciphered result. The incoming ciphertext then becomes the new chaining value.
- R8: In ECB operation the chaining value is left unchanged.
- R9: `out_valid` rises on the 17th rising edge after the accepting edge for a single-key block, and on the 51st for a triple-key block.
- R10: While `out_valid` is high and `out_ready` is low, the output words hold steady and `in_ready` stays low.
- R11: `iv_load` while the engine is empty writes `iv_in` to the chaining register. If it coincides with the acceptance of a CBC block, that block chains with `iv_in`. `iv_load` while a block is in flight or waiting is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input block offered |
| in_ready | output | 1 | Engine empty; block taken when both high |
| din_hi | input | 32 | Input block bits 1..32 |
| din_lo | input | 32 | Input block bits 33..64 |
| key1 | input | 64 | First key (the only key in single-key mode) |
| key2 | input | 64 | Second key |
| key3 | input | 64 | Third key |
| cfg_triple | input | 1 | 1: three-key cascade, 0: single key |
| cfg_chain | input | 1 | 1: CBC, 0: ECB |
| cfg_encrypt | input | 1 | 1: encrypt, 0: decrypt |
| iv_load | input | 1 | Write `iv_in` into the chaining register |
| iv_in | input | 64 | New chaining value |
| iv_out | output | 64 | Current chaining value |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| dout_hi | output | 32 | Result bits 1..32 |
| dout_lo | output | 32 | Result bits 33..64 |

## Verification
The functions that can meet in one cycle are the chaining-register write from `iv_load` and the acceptance of a CBC block, which reads that same register. The bench drives `iv_load` in the accepting cycle with a value that differs from the stored one. It then checks the output and `iv_out` against results computed from `iv_in`. A second collision pulses `iv_load` while a block is in flight or while its result is being back-pressured. The bench then confirms that `iv_out` shows only the hardware update.

// File: rtl/tdes_pkg.sv
package tdes_pkg;
  localparam int BLK_W  = 64;
  localparam int HALF_W = 32;
  localparam int CD_W   = 56;
  localparam int SUB_W  = 48;
  localparam int ROUNDS = 16;
  localparam int NKEYS  = 3;
  localparam int RND_W  = $clog2(ROUNDS);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} eng_state_t;

  // source bit (1-based, MSB=1) of initial-permutation output position i
  function automatic int ip_src(input int i);
    int r, c;
    r = i / 8;
    c = i % 8;
    return (r < 4) ? (58 + 2*r - 8*c) : (57 + 2*(r-4) - 8*c);
  endfunction

  function automatic logic [63:0] perm_ip(input logic [63:0] x);
    logic [63:0] y;
    for (int i = 0; i < 64; i++) y[63-i] = x[64-ip_src(i)];
    return y;
  endfunction

  function automatic logic [63:0] perm_fp(input logic [63:0] x);
    logic [63:0] y;
    for (int i = 0; i < 64; i++) y[64-ip_src(i)] = x[63-i];
    return y;
  endfunction

  function automatic logic [47:0] expand(input logic [31:0] r);
    logic [47:0] y;
    for (int g = 0; g < 8; g++)
      for (int j = 0; j < 6; j++)
        y[47-(6*g+j)] = r[32-(((4*g+j+31) % 32)+1)];
    return y;
  endfunction

  function automatic int p_src(input int i);
    case (i)
      0: return 16;  1: return 7;   2: return 20;  3: return 21;
      4: return 29;  5: return 12;  6: return 28;  7: return 17;
      8: return 1;   9: return 15;  10: return 23; 11: return 26;
      12: return 5;  13: return 18; 14: return 31; 15: return 10;
      16: return 2;  17: return 8;  18: return 24; 19: return 14;
      20: return 32; 21: return 27; 22: return 3;  23: return 9;
      24: return 19; 25: return 13; 26: return 30; 27: return 6;
      28: return 22; 29: return 11; 30: return 4;  default: return 25;
    endcase
  endfunction

  function automatic int pc1_src(input int i);
    case (i)
      0: return 57;  1: return 49;  2: return 41;  3: return 33;  4: return 25;  5: return 17;  6: return 9;
      7: return 1;   8: return 58;  9: return 50;  10: return 42; 11: return 34; 12: return 26; 13: return 18;
      14: return 10; 15: return 2;  16: return 59; 17: return 51; 18: return 43; 19: return 35; 20: return 27;
      21: return 19; 22: return 11; 23: return 3;  24: return 60; 25: return 52; 26: return 44; 27: return 36;
      28: return 63; 29: return 55; 30: return 47; 31: return 39; 32: return 31; 33: return 23; 34: return 15;
      35: return 7;  36: return 62; 37: return 54; 38: return 46; 39: return 38; 40: return 30; 41: return 22;
      42: return 14; 43: return 6;  44: return 61; 45: return 53; 46: return 45; 47: return 37; 48: return 29;
      49: return 21; 50: return 13; 51: return 5;  52: return 28; 53: return 20; 54: return 12; default: return 4;
    endcase
  endfunction

  function automatic int pc2_src(input int i);
    case (i)
      0: return 14;  1: return 17;  2: return 11;  3: return 24;  4: return 1;   5: return 5;
      6: return 3;   7: return 28;  8: return 15;  9: return 6;   10: return 21; 11: return 10;
      12: return 23; 13: return 19; 14: return 12; 15: return 4;  16: return 26; 17: return 8;
      18: return 16; 19: return 7;  20: return 27; 21: return 20; 22: return 13; 23: return 2;
      24: return 41; 25: return 52; 26: return 31; 27: return 37; 28: return 47; 29: return 55;
      30: return 30; 31: return 40; 32: return 51; 33: return 45; 34: return 33; 35: return 48;
      36: return 44; 37: return 49; 38: return 39; 39: return 56; 40: return 34; 41: return 53;
      42: return 46; 43: return 42; 44: return 50; 45: return 36; 46: return 29; default: return 32;
    endcase
  endfunction

  function automatic logic [55:0] perm_pc1(input logic [63:0] k);
    logic [55:0] y;
    for (int i = 0; i < 56; i++) y[55-i] = k[64-pc1_src(i)];
    return y;
  endfunction

  function automatic logic [47:0] perm_pc2(input logic [55:0] cd);
    logic [47:0] y;
    for (int i = 0; i < 48; i++) y[47-i] = cd[56-pc2_src(i)];
    return y;
  endfunction

  function automatic logic [31:0] perm_p(input logic [31:0] x);
    logic [31:0] y;
    for (int i = 0; i < 32; i++) y[31-i] = x[32-p_src(i)];
    return y;
  endfunction

  // left-rotate amount of the key schedule for round index r (0-based)
  function automatic int shift_amt(input int r);
    return (r == 0 || r == 1 || r == 8 || r == 15) ? 1 : 2;
  endfunction

  function automatic logic [55:0] rot_cd(input logic [55:0] cd, input int n, input logic left);
    logic [27:0] c, d;
    c = cd[55:28];
    d = cd[27:0];
    if (left) begin
      if (n == 1) begin c = {c[26:0], c[27]};    d = {d[26:0], d[27]};    end
      else        begin c = {c[25:0], c[27:26]}; d = {d[25:0], d[27:26]}; end
    end else begin
      if (n == 1) begin c = {c[0], c[27:1]};    d = {d[0], d[27:1]};    end
      else        begin c = {c[1:0], c[27:2]};  d = {d[1:0], d[27:2]};  end
    end
    return {c, d};
  endfunction

  // one substitution-box row, 16 nibbles, column 0 in the top nibble
  function automatic logic [63:0] sbox_row(input int idx);
    case (idx)
      0:  return 64'hE4D12FB83A6C5907; 1:  return 64'h0F74E2D1A6CB9538;
      2:  return 64'h41E8D62BFC973A50; 3:  return 64'hFC8249175B3EA06D;
      4:  return 64'hF18E6B34972DC05A; 5:  return 64'h3D47F28EC01A69B5;
      6:  return 64'h0E7BA4D158C6932F; 7:  return 64'hD8A13F42B67C05E9;
      8:  return 64'hA09E63F51DC7B428; 9:  return 64'hD709346A285ECBF1;
      10: return 64'hD6498F30B12C5AE7; 11: return 64'h1AD069874FE3B52C;
      12: return 64'h7DE3069A1285BC4F; 13: return 64'hD8B56F03472C1AE9;
      14: return 64'hA690CB7DF13E5284; 15: return 64'h3F06A1D8945BC72E;
      16: return 64'h2C417AB6853FD0E9; 17: return 64'hEB2C47D150FA3986;
      18: return 64'h421BAD78F9C5630E; 19: return 64'hB8C71E2D6F09A453;
      20: return 64'hC1AF92680D34E75B; 21: return 64'hAF427C9561DE0B38;
      22: return 64'h9EF528C3704A1DB6; 23: return 64'h432C95FABE17608D;
      24: return 64'h4B2EF08D3C975A61; 25: return 64'hD0B7491AE35C2F86;
      26: return 64'h14BDC37EAF680592; 27: return 64'h6BD814A7950FE23C;
      28: return 64'hD2846FB1A93E50C7; 29: return 64'h1FD8A374C56B0E92;
      30: return 64'h7B419CE206ADF358; default: return 64'h21E74A8DFC90356B;
    endcase
  endfunction

  function automatic logic [31:0] feistel(input logic [31:0] r, input logic [47:0] k);
    logic [47:0] x;
    logic [31:0] s;
    logic [63:0] row;
    logic [5:0]  b;
    int col;
    x = expand(r) ^ k;
    for (int g = 0; g < 8; g++) begin
      b   = x[47-6*g -: 6];
      row = sbox_row(4*g + int'({b[5], b[0]}));
      col = int'(b[4:1]);
      s[31-4*g -: 4] = row[60-4*col +: 4];
    end
    return perm_p(s);
  endfunction
endpackage

// File: rtl/tdes_keysched.sv
module tdes_keysched
  import tdes_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [BLK_W-1:0] key,
  input  logic             decrypt,
  input  logic [RND_W-1:0] round_idx,
  output logic [SUB_W-1:0] subkey
);
  logic [CD_W-1:0] cd_q, cur_cd;
  logic            dec_q;

  // encrypt: rotate left before use; decrypt: use, then rotate right
  always_comb begin
    cur_cd = dec_q ? cd_q : rot_cd(cd_q, shift_amt(int'(round_idx)), 1'b1);
    subkey = perm_pc2(cur_cd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cd_q  <= '0;
      dec_q <= 1'b0;
    end else if (load) begin
      cd_q  <= perm_pc1(key);
      dec_q <= decrypt;
    end else if (step) begin
      cd_q  <= dec_q ? rot_cd(cd_q, shift_amt(ROUNDS-1-int'(round_idx)), 1'b0) : cur_cd;
    end
  end

  // checker state: a full pass of shifts must return to the loaded halves
  logic [CD_W-1:0] cd_ref;
  logic [RND_W:0]  steps_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cd_ref  <= '0;
      steps_q <= '0;
    end else if (load) begin
      cd_ref  <= perm_pc1(key);
      steps_q <= '0;
    end else if (step && steps_q != (RND_W+1)'(ROUNDS)) begin
      steps_q <= steps_q + 1'b1;
    end
  end

  // R3
  sched_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (steps_q == (RND_W+1)'(ROUNDS)) |-> (cd_q == cd_ref));
endmodule

// File: rtl/tdes_iter_core.sv
module tdes_iter_core
  import tdes_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             chain,
  input  logic [BLK_W-1:0] blk_in,
  input  logic [BLK_W-1:0] key,
  input  logic             decrypt,
  output logic             fin,
  output logic [BLK_W-1:0] blk_out
);
  logic [HALF_W-1:0] l_q, r_q;
  logic [RND_W-1:0]  rnd_q;
  logic              run_q, fin_q;
  logic [SUB_W-1:0]  subkey;
  logic              last_rnd;

  assign last_rnd = run_q && (rnd_q == RND_W'(ROUNDS-1));

  tdes_keysched u_ks (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .step      (run_q),
    .key       (key),
    .decrypt   (decrypt),
    .round_idx (rnd_q),
    .subkey    (subkey)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_q   <= '0;
      r_q   <= '0;
      rnd_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= last_rnd;
      if (start) begin
        // a following pass starts from the swapped halves: the inverse
        // permutation and the next initial permutation cancel
        {l_q, r_q} <= chain ? {r_q, l_q} : perm_ip(blk_in);
        rnd_q      <= '0;
        run_q      <= 1'b1;
      end else if (run_q) begin
        l_q   <= r_q;
        r_q   <= l_q ^ feistel(r_q, subkey);
        rnd_q <= rnd_q + 1'b1;
        if (last_rnd) run_q <= 1'b0;
      end
    end
  end

  assign fin     = fin_q;
  assign blk_out = perm_fp({r_q, l_q});

  // R9
  core_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !run_q);
  // R9
  core_fin_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> !run_q && $past(run_q));
endmodule

// File: rtl/tdes_chain_engine.sv
module tdes_chain_engine
  import tdes_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [HALF_W-1:0] din_hi,
  input  logic [HALF_W-1:0] din_lo,
  input  logic [BLK_W-1:0]  key1,
  input  logic [BLK_W-1:0]  key2,
  input  logic [BLK_W-1:0]  key3,
  input  logic              cfg_triple,
  input  logic              cfg_chain,
  input  logic              cfg_encrypt,
  input  logic              iv_load,
  input  logic [BLK_W-1:0]  iv_in,
  output logic [BLK_W-1:0]  iv_out,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [HALF_W-1:0] dout_hi,
  output logic [HALF_W-1:0] dout_lo
);
  localparam int PASS_W = $clog2(NKEYS);
  localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(NKEYS-1);

  eng_state_t       state_q;
  logic [PASS_W-1:0] pass_q, nxt_pass, key_sel;
  logic             enc_q, cbc_q, tri_q;
  logic [BLK_W-1:0] cin_q, iv_q, out_q;
  logic [BLK_W-1:0] din, iv_eff, pre_blk, core_out, core_key, result;
  logic [NKEYS-1:0][BLK_W-1:0] key_set;
  logic             accept, core_fin, more, core_start, core_dec;
  logic             eff_enc, eff_tri;

  assign din     = {din_hi, din_lo};
  assign key_set = {key3, key2, key1};
  assign accept  = in_valid && in_ready;
  assign iv_eff  = iv_load ? iv_in : iv_q;
  assign pre_blk = (cfg_chain && cfg_encrypt) ? (din ^ iv_eff) : din;
  assign more    = tri_q && (pass_q != LAST_PASS);

  // key and direction of the pass about to start
  always_comb begin
    eff_enc  = accept ? cfg_encrypt : enc_q;
    eff_tri  = accept ? cfg_triple  : tri_q;
    nxt_pass = accept ? '0 : pass_q + 1'b1;
    if (!eff_tri) begin
      key_sel  = '0;
      core_dec = !eff_enc;
    end else if (eff_enc) begin
      key_sel  = nxt_pass;
      core_dec = (nxt_pass == PASS_W'(1));
    end else begin
      key_sel  = LAST_PASS - nxt_pass;
      core_dec = (nxt_pass != PASS_W'(1));
    end
    core_key   = key_set[key_sel];
    core_start = accept || (state_q == ST_RUN && core_fin && more);
  end

  tdes_iter_core u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (core_start),
    .chain   (!accept),
    .blk_in  (pre_blk),
    .key     (core_key),
    .decrypt (core_dec),
    .fin     (core_fin),
    .blk_out (core_out)
  );

  assign result = (cbc_q && !enc_q) ? (core_out ^ iv_q) : core_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pass_q  <= '0;
      enc_q   <= 1'b0;
      cbc_q   <= 1'b0;
      tri_q   <= 1'b0;
      cin_q   <= '0;
      iv_q    <= '0;
      out_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (iv_load) iv_q <= iv_in;
          if (accept) begin
            state_q <= ST_RUN;
            pass_q  <= '0;
            enc_q   <= cfg_encrypt;
            cbc_q   <= cfg_chain;
            tri_q   <= cfg_triple;
            cin_q   <= din;
          end
        end
        ST_RUN: begin
          if (core_fin) begin
            if (more) begin
              pass_q <= nxt_pass;
            end else begin
              out_q   <= result;
              state_q <= ST_DONE;
              if (cbc_q) iv_q <= enc_q ? core_out : cin_q;
            end
          end
        end
        ST_DONE: begin
          if (out_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_DONE);
  assign dout_hi   = out_q[BLK_W-1:HALF_W];
  assign dout_lo   = out_q[HALF_W-1:0];
  assign iv_out    = iv_q;

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_q)));
  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  // R8
  ecb_iv_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && !cbc_q) |=> $stable(iv_q));
  // R11
  busy_iv_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !core_fin) |=> $stable(iv_q));
  // R4
  single_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && !tri_q) |-> (pass_q == '0));
endmodule

// File: tb/tdes_chain_engine_test.sv
`timescale 1ns/1ps
module tdes_chain_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b0, iv_load = 1'b0;
  logic        cfg_triple = 1'b0, cfg_chain = 1'b0, cfg_encrypt = 1'b1;
  logic [31:0] din_hi = '0, din_lo = '0;
  logic [63:0] key1 = '0, key2 = '0, key3 = '0, iv_in = '0;
  logic        in_ready, out_valid;
  logic [63:0] iv_out;
  logic [31:0] dout_hi, dout_lo;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  tdes_chain_engine uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .din_hi(din_hi), .din_lo(din_lo), .key1(key1), .key2(key2), .key3(key3),
    .cfg_triple(cfg_triple), .cfg_chain(cfg_chain), .cfg_encrypt(cfg_encrypt),
    .iv_load(iv_load), .iv_in(iv_in), .iv_out(iv_out), .out_valid(out_valid),
    .out_ready(out_ready), .dout_hi(dout_hi), .dout_lo(dout_lo)
  );

  localparam logic [63:0] KA = 64'h133457799BBCDFF1;
  localparam logic [63:0] PA = 64'h0123456789ABCDEF;
  localparam logic [63:0] CA = 64'h85E813540F0AB405;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic mode(input logic tri3, input logic cbc, input logic enc);
    cfg_triple = tri3; cfg_chain = cbc; cfg_encrypt = enc;
  endtask

  // one block: optional iv_load with accept, optional mid-run iv poke,
  // optional output stall; returns result and accept-to-valid latency
  task automatic xfer(input logic [63:0] blk, input logic ld, input logic [63:0] ldv,
                      input logic poke, input int stall,
                      output logic [63:0] res, output int lat);
    @(negedge clk);
    in_valid = 1'b1; din_hi = blk[63:32]; din_lo = blk[31:0];
    iv_load = ld; iv_in = ldv;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; iv_load = 1'b0;
    lat = 0;
    if (poke) begin
      iv_load = 1'b1; iv_in = ~ldv;
    end
    while (!out_valid && lat < 200) begin
      @(negedge clk);
      lat++;
      if (lat == 5) iv_load = 1'b0;
    end
    res = {dout_hi, dout_lo};
    for (int s = 0; s < stall; s++) begin
      if (s == 1 && poke) begin iv_load = 1'b1; iv_in = 64'hDEAD_BEEF_0BAD_F00D; end
      @(negedge clk);
      iv_load = 1'b0;
      chk("R10 hold", {dout_hi, dout_lo}, res);
      chk("R10 in_ready low", {63'd0, in_ready}, 64'd0);
    end
    iv_load = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic loadiv(input logic [63:0] v);
    @(negedge clk);
    iv_load = 1'b1; iv_in = v;
    @(negedge clk);
    iv_load = 1'b0;
  endtask

  initial begin
    #(4*150000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [63:0] r, r2, p, ivs, c0, c1, c2, c3;
    int lat;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 in_ready", {63'd0, in_ready}, 64'd1);
    chk("R1 out_valid", {63'd0, out_valid}, 64'd0);
    chk("R1 iv_out", iv_out, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 standard vectors, R9 single latency
    key1 = KA; mode(0, 0, 1);
    xfer(PA, 0, 0, 0, 0, r, lat);
    chk("R2 known vector", r, CA);
    chk("R9 single latency", 64'(lat), 64'd17);
    chk("R8 ecb iv", iv_out, 64'd0);
    key1 = 64'h0E329232EA6D0D73;
    xfer(64'h8787878787878787, 0, 0, 0, 0, r, lat);
    chk("R2 second vector", r, 64'd0);
    key1 = ~KA;
    xfer(~PA, 0, 0, 0, 0, r, lat);
    chk("R2 complement", r, ~CA);

    // R3 single decrypt
    key1 = KA; mode(0, 0, 0);
    xfer(CA, 0, 0, 0, 0, r, lat);
    chk("R3 decrypt vector", r, PA);

    // R4 triple encrypt order: K1=K2 cancel, leaving E(K3)
    key1 = 64'hA5A5_5A5A_0F0F_F0F0; key2 = key1; key3 = KA; mode(1, 0, 1);
    xfer(PA, 0, 0, 0, 0, r, lat);
    chk("R4 triple encrypt order", r, CA);
    chk("R9 triple latency", 64'(lat), 64'd51);

    // R5 triple decrypt order: K2=K3 cancel, leaving D(K1)
    key1 = KA; key2 = 64'h3C3C_C3C3_1234_8765; key3 = key2; mode(1, 0, 0);
    xfer(CA, 0, 0, 0, 0, r, lat);
    chk("R5 triple decrypt order", r, PA);

    // R6 CBC encrypt, R11 iv_load with accept in the same cycle
    key1 = KA; mode(0, 1, 1);
    loadiv(64'h1111_2222_3333_4444);
    ivs = 64'hFEDC_BA98_7654_3210;
    xfer(PA ^ ivs, 1, ivs, 0, 0, r, lat);
    chk("R6 R11 cbc encrypt out", r, CA);
    chk("R6 cbc encrypt iv", iv_out, CA);

    // R7 CBC decrypt, R11 ignore while busy and while stalled, R10 stall
    mode(0, 1, 0);
    ivs = 64'h0F1E_2D3C_4B5A_6978;
    loadiv(ivs);
    chk("R11 idle load", iv_out, ivs);
    xfer(CA, 0, ivs, 1, 4, r, lat);
    chk("R7 cbc decrypt out", r, PA ^ ivs);
    chk("R7 R11 cbc decrypt iv", iv_out, CA);

    // R8 ECB with busy iv poke leaves iv intact
    mode(0, 0, 1);
    xfer(PA, 0, iv_out, 1, 3, r, lat);
    chk("R8 R11 ecb iv unchanged", iv_out, CA);

    // R3 sweep: single and triple round trips
    key1 = 64'h0123_4567_89AB_CDEF; key2 = 64'hFEDC_BA98_7654_3210; key3 = 64'h89AB_CDEF_0123_4567;
    for (int i = 0; i < 16; i++) begin
      p = {32'h9E3779B9 * 32'(i+1), 32'h7F4A7C15 ^ (32'(i) * 32'h01000193)};
      for (int t = 0; t < 2; t++) begin
        mode(t[0], 0, 1);
        xfer(p, 0, 0, 0, 0, r, lat);
        mode(t[0], 0, 0);
        xfer(r, 0, 0, 0, 0, r2, lat);
        chk(t == 0 ? "R3 single round trip" : "R3 triple round trip", r2, p);
      end
    end

    // R6 R7 CBC stream across four triple-key blocks
    mode(1, 1, 1);
    loadiv(64'h5555_AAAA_3333_CCCC);
    xfer(64'h1, 0, 0, 0, 0, c0, lat);
    xfer(64'h2, 0, 0, 0, 0, c1, lat);
    xfer(64'h3, 0, 0, 0, 0, c2, lat);
    xfer(64'h4, 0, 0, 0, 0, c3, lat);
    chk("R6 stream iv", iv_out, c3);
    mode(1, 1, 0);
    loadiv(64'h5555_AAAA_3333_CCCC);
    xfer(c0, 0, 0, 0, 0, r, lat); chk("R7 stream b0", r, 64'h1);
    xfer(c1, 0, 0, 0, 0, r, lat); chk("R7 stream b1", r, 64'h2);
    xfer(c2, 0, 0, 0, 0, r, lat); chk("R7 stream b2", r, 64'h3);
    xfer(c3, 0, 0, 0, 0, r, lat); chk("R7 stream b3", r, 64'h4);
    chk("R7 stream iv", iv_out, c3);

    summary();
  end
endmodule